// File: doc/BRIEF.md
# Management Command Unit with Responding PHY Register File

This block is a host-facing front end for PHY management traffic. The host reaches four host registers through a simple one-port read/write interface. These are a control register, a command register, a write-data register and a read-data register. A write to the command register with its start bit set launches one management transaction against an internal PHY model, and the transaction completes after a fixed number of cycles. The PHY model responds at one configurable 5-bit address and holds thirty-two 16-bit registers.

Most PHY registers simply store what was written. A few return values that the PHY computes itself. The basic status register reports fixed abilities. The link-partner ability register and a vendor speed/duplex register are rebuilt from whatever the host last placed in the advertisement register, so a driver always sees the partner agreeing with its best advertised mode. Serial bit timing on the management wires is not modelled. Each transaction is atomic and signals completion with a one-cycle pulse and a sticky ready flag.

Top module: `mdio_cmd_unit`

## Requirements
- R1: After reset, the control, command, write-data and read-data host registers read 0, and the ready bit reads 0. PHY registers 0, 2, 3 and 4 read 0x3100, 0x0300, 0xE400 and 0x01E1, and every other stored PHY register reads 0. A later reset restores these values even after PHY writes.
- R2: The host map is 0 = control, 1 = command, 2 = write-data and 3 = read-data, and host_rdata shows the selected register one cycle after host_addr is presented. The command word carries the PHY address in bits 28:24, the PHY register in bits 20:16, the opcode in bits 15:14 and start in bit 11. Opcode 1 stores write-data[15:0] into the addressed PHY register, and opcode 2 loads that register into read-data[15:0].
- R3: An accepted command raises cmd_done for exactly one cycle, CMD_LAT clock edges after the edge that accepted it. The ready bit (control bit 7) clears on acceptance and sets together with cmd_done.
- R4: Opcodes 0 and 3 change no PHY register and leave read-data unchanged. They complete like valid commands, with cmd_bad_op high in the same cycle as cmd_done.
- R5: A command whose PHY address differs from PHY_ADDR (default 7) writes nothing, and a read to it loads 0 into read-data.
- R6: PHY register 1 always reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1), whatever has been written to it.
- R7: PHY register 5 reads 0x4000 ORed with bits 8:5 of the advertisement register (register 4).
- R8: PHY register 18 reads bit 10 set when advertisement bit 7 or bit 8 is set, and bit 11 set when advertisement bit 8 or bit 6 is set. All of its other bits read 0.
- R9: The control register keeps only host bits 6:0, with bit 6 as enable and bits 5:0 as the divider. cfg_error is high while enable is set and the divider is zero.
- R10: A start request that arrives while a command is in flight, including in its completion cycle, is dropped but still stored in the command register. A command word with bit 11 clear is stored and launches nothing.
- R11: A write command uses the write-data value held when the command was accepted. Host writes to write-data while the command is in flight do not reach the PHY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_bad_op | output | 1 | Completion carried an invalid opcode |
| cfg_error | output | 1 | Enabled with a zero clock divider |

## Verification
Two events can share one clock edge: a command finishing and a new start request arriving. The host can also rewrite write-data while the earlier command is still pending. The bench launches a write and then drives, edge by edge, a write-data overwrite one edge later. It follows with a second start request timed to land on the completion edge itself. The result is judged by checking three things. cmd_done must appear exactly on that edge and must never repeat. The first target register must hold the write-data value captured at acceptance. The second target must stay untouched while the command register still shows the dropped word.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int HOST_W   = 32;
  localparam int PHY_AW   = 5;
  localparam int REG_DW   = 16;
  localparam int CTRL_W   = 7;

  // command word field positions (decoded by the controller)
  localparam int FLD_PHY_LSB = 24;
  localparam int FLD_REG_LSB = 16;
  localparam int FLD_OP_LSB  = 14;
  localparam int FLD_GO_BIT  = 11;

  typedef enum logic [1:0] {
    HSEL_CTRL  = 2'd0,
    HSEL_CMD   = 2'd1,
    HSEL_WDATA = 2'd2,
    HSEL_RDATA = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    OP_RSV0  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSV3  = 2'd3
  } mdio_op_e;

  // PHY registers with computed read values
  localparam int PREG_STATUS  = 1;
  localparam int PREG_ADV     = 4;
  localparam int PREG_PARTNER = 5;
  localparam int PREG_SPEED   = 18;

  localparam logic [15:0] STATUS_VAL   = 16'h782E;
  localparam logic [15:0] PARTNER_BASE = 16'h4000;
  localparam logic [15:0] ADV_MODES    = 16'h01E0;

  localparam int ADV_10FULL  = 6;
  localparam int ADV_100HALF = 7;
  localparam int ADV_100FULL = 8;
  localparam int SPD_100_BIT = 10;
  localparam int SPD_FDX_BIT = 11;

endpackage

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_cmd_pkg::*;
#(
  parameter int AW = PHY_AW,
  parameter int DW = REG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    mem_q;
  logic [DEPTH-1:0] written_q;
  logic             vld_q;
  logic [AW-1:0]    raddr_q;
  logic [DW-1:0]    adv_q;
  logic [DW-1:0]    stored;

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    case (a)
      AW'(0):        dflt = DW'(16'h3100);
      AW'(2):        dflt = DW'(16'h0300);
      AW'(3):        dflt = DW'(16'hE400);
      AW'(PREG_ADV): dflt = DW'(16'h01E1);
      default:       dflt = '0;
    endcase
  endfunction

  // plain storage, no reset: maps onto a RAM primitive
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // per-entry written flags stand in for a reset of the array
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      vld_q     <= 1'b0;
      raddr_q   <= '0;
      adv_q     <= DW'(16'h01E1);
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      if (we && waddr == AW'(PREG_ADV)) adv_q <= wdata;
      vld_q   <= written_q[raddr];
      raddr_q <= raddr;
    end
  end

  always_comb begin
    stored = vld_q ? mem_q : dflt(raddr_q);
    rdata  = stored;
    case (raddr_q)
      AW'(PREG_STATUS):  rdata = DW'(STATUS_VAL);
      AW'(PREG_PARTNER): rdata = DW'(PARTNER_BASE) | (adv_q & DW'(ADV_MODES));
      AW'(PREG_SPEED): begin
        rdata              = '0;
        rdata[SPD_100_BIT] = adv_q[ADV_100HALF] | adv_q[ADV_100FULL];
        rdata[SPD_FDX_BIT] = adv_q[ADV_100FULL] | adv_q[ADV_10FULL];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int AW       = PHY_AW,
  parameter int DW       = REG_DW,
  parameter int CMD_LAT  = 4,
  parameter int PHY_ADDR = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] phy_in,
  input  logic [AW-1:0] reg_in,
  input  logic [1:0]    op_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] phy_rdata,
  output logic          busy,
  output logic          ready,
  output logic          done,
  output logic          bad_op,
  output logic [DW-1:0] rd_word,
  output logic          phy_we,
  output logic [AW-1:0] phy_reg,
  output logic [DW-1:0] phy_wdata
);

  localparam int CW = (CMD_LAT > 2) ? $clog2(CMD_LAT) : 1;

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] phy_q;
  logic [AW-1:0] reg_q;
  mdio_op_e      op_q;
  logic [DW-1:0] wd_q;
  logic          busy_q, ready_q, done_q, bad_q;
  logic [DW-1:0] rd_q;
  logic          last;
  logic          at_phy;
  logic          op_ok;

  assign last   = (cnt_q == CW'(CMD_LAT - 1));
  assign at_phy = (phy_q == AW'(PHY_ADDR));
  assign op_ok  = (op_q == OP_WRITE) || (op_q == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      op_q    <= OP_RSV0;
      wd_q    <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (launch && !busy_q) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        ready_q <= 1'b0;
        phy_q   <= phy_in;
        reg_q   <= reg_in;
        op_q    <= mdio_op_e'(op_in);
        wd_q    <= wdata_in;
      end else if (busy_q) begin
        if (last) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
          bad_q   <= !op_ok;
          if (op_q == OP_READ) rd_q <= at_phy ? phy_rdata : '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign phy_we    = busy_q && last && (op_q == OP_WRITE) && at_phy;
  assign phy_reg   = reg_q;
  assign phy_wdata = wd_q;
  assign busy      = busy_q;
  assign ready     = ready_q;
  assign done      = done_q;
  assign bad_op    = bad_q;
  assign rd_word   = rd_q;

endmodule

// File: rtl/mdio_cmd_unit.sv
module mdio_cmd_unit
  import mdio_cmd_pkg::*;
#(
  parameter int PHY_ADDR = 7,
  parameter int CMD_LAT  = 4,
  parameter int AW       = PHY_AW,
  parameter int DW       = REG_DW,
  parameter int HW       = HOST_W,
  parameter int CW       = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          cmd_done,
  output logic          cmd_bad_op,
  output logic          cfg_error
);

  localparam int DIV_W = CW - 1;

  logic [CW-1:0] ctrl_q;
  logic [HW-1:0] cmd_q;
  logic [DW-1:0] wdata_q;
  logic          launch;
  logic          cmd_busy, cmd_ready;
  logic [DW-1:0] rd_word;
  logic          phy_we;
  logic [AW-1:0] phy_reg;
  logic [DW-1:0] phy_wdata;
  logic [DW-1:0] phy_rdata;
  logic [HW-1:0] rd_mux;
  host_sel_e     sel;

  assign sel    = host_sel_e'(host_addr);
  assign launch = host_wr && (sel == HSEL_CMD) && host_wdata[FLD_GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      wdata_q <= '0;
    end else if (host_wr) begin
      case (sel)
        HSEL_CTRL:  ctrl_q  <= host_wdata[CW-1:0];
        HSEL_CMD:   cmd_q   <= host_wdata;
        HSEL_WDATA: wdata_q <= host_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  mdio_cmd_ctrl #(
    .AW(AW), .DW(DW), .CMD_LAT(CMD_LAT), .PHY_ADDR(PHY_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .phy_in    (host_wdata[FLD_PHY_LSB +: AW]),
    .reg_in    (host_wdata[FLD_REG_LSB +: AW]),
    .op_in     (host_wdata[FLD_OP_LSB +: 2]),
    .wdata_in  (wdata_q),
    .phy_rdata (phy_rdata),
    .busy      (cmd_busy),
    .ready     (cmd_ready),
    .done      (cmd_done),
    .bad_op    (cmd_bad_op),
    .rd_word   (rd_word),
    .phy_we    (phy_we),
    .phy_reg   (phy_reg),
    .phy_wdata (phy_wdata)
  );

  mdio_phy_regs #(.AW(AW), .DW(DW)) u_phy (
    .clk   (clk),
    .rst   (rst),
    .we    (phy_we),
    .waddr (phy_reg),
    .wdata (phy_wdata),
    .raddr (phy_reg),
    .rdata (phy_rdata)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      HSEL_CTRL: begin
        rd_mux[CW-1:0] = ctrl_q;
        rd_mux[CW]     = cmd_ready;
      end
      HSEL_CMD:   rd_mux = cmd_q;
      HSEL_WDATA: rd_mux[DW-1:0] = wdata_q;
      default:    rd_mux[DW-1:0] = rd_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end

  assign cfg_error = ctrl_q[CW-1] && (ctrl_q[DIV_W-1:0] == '0);

endmodule

// File: rtl/mdio_cmd_unit_chk.sv
module mdio_cmd_unit_chk #(
  parameter int CMD_LAT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic [1:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        cmd_done,
  input logic        cmd_bad_op,
  input logic        cfg_error,
  input logic        busy,
  input logic        ready,
  input logic        phy_we
);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == CMD_LAT));

  p_ready_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ready);

  p_ready_set_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> ready);

  p_bad_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_bad_op |-> cmd_done);

  p_we_in_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    phy_we |-> busy);

  p_we_then_done_r2: assert property (@(posedge clk) disable iff (rst)
    phy_we |=> cmd_done);

  p_cfg_err_r9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && host_wdata[6] && host_wdata[5:0] == 6'd0)
      |=> cfg_error);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !busy);

endmodule

bind mdio_cmd_unit mdio_cmd_unit_chk #(.CMD_LAT(CMD_LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .cmd_done   (cmd_done),
  .cmd_bad_op (cmd_bad_op),
  .cfg_error  (cfg_error),
  .busy       (cmd_busy),
  .ready      (cmd_ready),
  .phy_we     (phy_we)
);

// File: tb/mdio_cmd_unit_bench.sv
module mdio_cmd_unit_bench;

  localparam int LAT = 4;
  localparam int PHY = 7;
  localparam logic [1:0] A_CTRL = 2'd0, A_CMD = 2'd1, A_WD = 2'd2, A_RD = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_done, cmd_bad_op, cfg_error;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mdio_cmd_unit #(.PHY_ADDR(PHY), .CMD_LAT(LAT)) u_mdio_cmd_unit (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_done(cmd_done),
    .cmd_bad_op(cmd_bad_op), .cfg_error(cfg_error)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(input int op, input int phy, input int rg, input bit go);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic run_cmd(input int op, input int phy, input int rg, output int cyc, output logic bad);
    host_write(A_CMD, cmd_word(op, phy, rg, 1'b1));
    cyc = 0;
    while (!cmd_done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    bad = cmd_bad_op;
  endtask

  task automatic phy_write(input int rg, input logic [15:0] v, input int phy);
    int c; logic b;
    host_write(A_WD, {16'h0, v});
    run_cmd(1, phy, rg, c, b);
  endtask

  task automatic phy_read(input int rg, input int phy, output logic [31:0] v);
    int c; logic b;
    run_cmd(2, phy, rg, c, b);
    host_read(A_RD, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cmd_done after reset", {31'h0, cmd_done}, 32'h0);
    host_read(A_CTRL, v); check("R1 ctrl and ready at reset", v, 32'h0);
    host_read(A_CMD, v);  check("R1 command reg at reset", v, 32'h0);
    host_read(A_RD, v);   check("R1 read-data at reset", v, 32'h0);
    phy_read(0, PHY, v);  check("R1 PHY reg0 default", v, 32'h3100);
    phy_read(2, PHY, v);  check("R1 PHY reg2 default", v, 32'h0300);
    phy_read(3, PHY, v);  check("R1 PHY reg3 default", v, 32'hE400);
    phy_read(4, PHY, v);  check("R1 PHY reg4 default", v, 32'h01E1);
    phy_read(9, PHY, v);  check("R1 PHY reg9 default", v, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] v; int c; logic b;
    host_write(A_WD, 32'h0000_1234);
    run_cmd(1, PHY, 9, c, b);
    check("R3 write latency", 32'(c), 32'(LAT));
    @(negedge clk);
    check("R3 done lasts one cycle", {31'h0, cmd_done}, 32'h0);
    host_read(A_CTRL, v); check("R3 ready set after done", {31'h0, v[7]}, 32'h1);
    run_cmd(2, PHY, 9, c, b);
    check("R3 read latency", 32'(c), 32'(LAT));
    host_read(A_RD, v); check("R2 read back reg9", v, 32'h1234);
    // ready clears at acceptance
    host_write(A_CMD, cmd_word(2, PHY, 9, 1'b1));
    host_addr = A_CTRL;
    @(negedge clk);
    check("R3 ready cleared while busy", {31'h0, host_rdata[7]}, 32'h0);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic t_bad_op();
    logic [31:0] v; int c; logic b;
    host_write(A_WD, 32'h0000_BEEF);
    run_cmd(0, PHY, 9, c, b);
    check("R4 opcode0 flagged", {31'h0, b}, 32'h1);
    check("R4 opcode0 completes on time", 32'(c), 32'(LAT));
    host_read(A_RD, v); check("R4 read-data kept after opcode0", v, 32'h1234);
    run_cmd(3, PHY, 9, c, b);
    check("R4 opcode3 flagged", {31'h0, b}, 32'h1);
    host_read(A_RD, v); check("R4 read-data kept after opcode3", v, 32'h1234);
    run_cmd(2, PHY, 9, c, b);
    check("R4 valid opcode not flagged", {31'h0, b}, 32'h0);
    host_read(A_RD, v); check("R4 reg9 unchanged", v, 32'h1234);
  endtask

  task automatic t_mismatch();
    logic [31:0] v;
    phy_read(9, 3, v);  check("R5 read at foreign address", v, 32'h0);
    phy_write(9, 16'h7777, 3);
    phy_read(9, PHY, v); check("R5 foreign write ignored", v, 32'h1234);
  endtask

  task automatic t_derived();
    logic [31:0] v;
    phy_read(1, PHY, v); check("R6 status value", v, 32'h782E);
    phy_write(1, 16'h0000, PHY);
    phy_read(1, PHY, v); check("R6 status after write", v, 32'h782E);
    phy_read(5, PHY, v); check("R7 partner with default adv", v, 32'h41E0);
    phy_read(18, PHY, v); check("R8 speed with default adv", v, 32'h0C00);
    phy_write(4, 16'h0041, PHY);
    phy_read(4, PHY, v); check("R2 adv readback", v, 32'h0041);
    phy_read(5, PHY, v); check("R7 partner 10-full only", v, 32'h4040);
    phy_read(18, PHY, v); check("R8 10-full gives duplex only", v, 32'h0800);
    phy_write(4, 16'h0080, PHY);
    phy_read(18, PHY, v); check("R8 100-half gives speed only", v, 32'h0400);
    phy_write(4, 16'h0100, PHY);
    phy_read(18, PHY, v); check("R8 100-full gives both", v, 32'h0C00);
    phy_write(4, 16'h0020, PHY);
    phy_read(18, PHY, v); check("R8 10-half gives none", v, 32'h0000);
    phy_read(5, PHY, v); check("R7 partner 10-half", v, 32'h4020);
    phy_write(4, 16'h0000, PHY);
    phy_read(5, PHY, v); check("R7 partner no modes", v, 32'h4000);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    host_write(A_CTRL, 32'hFFFF_FFC5);
    host_read(A_CTRL, v); check("R9 ctrl keeps bits 6:0 plus ready", v, 32'h0000_00C5);
    check("R9 no error with nonzero divider", {31'h0, cfg_error}, 32'h0);
    host_write(A_CTRL, 32'h0000_0040);
    check("R9 error enabled with zero divider", {31'h0, cfg_error}, 32'h1);
    host_write(A_CTRL, 32'h0000_0000);
    check("R9 no error when disabled", {31'h0, cfg_error}, 32'h0);
    host_write(A_CTRL, 32'h0000_003F);
    check("R9 no error divider only", {31'h0, cfg_error}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v; bit extra;
    host_write(A_WD, 32'h0000_A5A5);
    host_write(A_CMD, cmd_word(1, PHY, 10, 1'b1));
    for (int k = 1; k <= LAT; k++) begin
      host_wr = 1'b0;
      if (k == 1) begin
        host_wr = 1'b1; host_addr = A_WD; host_wdata = 32'h0000_5A5A;
      end else if (k == LAT) begin
        host_wr = 1'b1; host_addr = A_CMD; host_wdata = cmd_word(1, PHY, 11, 1'b1);
      end
      @(negedge clk);
    end
    host_wr = 1'b0;
    check("R3 done on completion edge", {31'h0, cmd_done}, 32'h1);
    extra = 1'b0;
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      if (cmd_done) extra = 1'b1;
    end
    check("R10 start at completion edge dropped", {31'h0, extra}, 32'h0);
    host_read(A_CMD, v); check("R10 dropped word still stored", v, cmd_word(1, PHY, 11, 1'b1));
    phy_read(10, PHY, v); check("R11 write used accepted data", v, 32'hA5A5);
    phy_read(11, PHY, v); check("R10 second target untouched", v, 32'h0);
    host_write(A_CMD, cmd_word(1, PHY, 11, 1'b0));
    extra = 1'b0;
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      if (cmd_done) extra = 1'b1;
    end
    check("R10 no start bit launches nothing", {31'h0, extra}, 32'h0);
    phy_read(11, PHY, v); check("R10 no start bit no write", v, 32'h0);
  endtask

  task automatic t_rereset();
    logic [31:0] v;
    phy_write(4, 16'h0020, PHY);
    do_reset();
    phy_read(4, PHY, v); check("R1 adv restored by reset", v, 32'h01E1);
    phy_read(9, PHY, v); check("R1 stored reg cleared by reset", v, 32'h0);
    phy_read(18, PHY, v); check("R1 R8 speed after reset", v, 32'h0C00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_bad_op();
    t_mismatch();
    t_derived();
    t_ctrl();
    t_collide();
    t_rereset();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule